// File: doc/BRIEF.md
# Memory Protection Region Checker

This block guards a small processor bus. It holds eight programmable protection regions. Each region has a base address, a power-of-two size, eight sub-region disable bits and a three-bit access-permission code. Every bus access is presented with its address, its direction and its privilege level. The block compares the access against the enabled regions, decides whether the access is allowed, and raises a registered fault flag when it is not.

Software programs the regions through four word registers. The first is a control word. The second is a region selector. The third is a base register, and a write to it can also pick the region. The fourth is an attribute register that holds the size, the sub-region disables, the permission code and the memory-type bits. The memory-type bits are only stored. When regions overlap, the highest-numbered matching region decides. Addresses in the system control space are never restricted.

Top module: `memprot_unit`

## Requirements
- R1: Configuration index 0 is control (bit 0 global enable, bit 2 default map for privileged accesses, bits 2:0 stored and read back, all others read 0). Index 1 is the region selector (3 bits). Index 2 is the base. Index 3 is the attribute. All registers reset to 0.
- R2: A base write with bit 4 set loads the region selector from bits 2:0 and updates that region. With bit 4 clear, the write goes to the region the selector names. A base read returns address bits 31:5, then 0 in bit 4, then the selector in bits 3:0.
- R3: Attribute layout: bit 0 region enable, bits 5:1 size code, bits 15:8 sub-region disables, bits 21:16 stored memory-type bits, bits 26:24 permission code. All other bits read back as 0.
- R4: A region spans 2^(size+1) bytes. Size codes below 4 behave as 32 bytes. Base bits below the region size are ignored, so the region is aligned to its own size.
- R5: When the size code is 7 or more, disable bit k removes the k-th eighth of the region (counting from the low address). For smaller regions the disable bits have no effect.
- R6: Permission codes: 000 no access; 001 privileged read/write, user none; 010 privileged read/write, user read; 011 read/write for all; 100 no access; 101 privileged read only, user none; 110 and 111 read only for all.
- R7: When several enabled regions match, the highest-numbered one decides the permission.
- R8: An access that matches no region faults if it is unprivileged. It also faults if it is privileged and control bit 2 is 0. It is allowed if it is privileged and control bit 2 is 1.
- R9: With control bit 0 clear, no access faults.
- R10: Addresses at or above 0xE0000000 never fault.
- R11: The fault output rises in the cycle after a faulting access is presented with its valid input high. An access presented with valid low, or an allowed access, leaves the fault output low in that next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 2 | Configuration register index |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data (combinational) |
| acc_valid_i | input | 1 | Bus access present |
| acc_addr_i | input | 32 | Bus access address |
| acc_write_i | input | 1 | Access is a write |
| acc_priv_i | input | 1 | Access is privileged |
| fault_o | output | 1 | Registered protection fault |

## Verification
The bench builds the block with its default eight regions and a 32-bit address, so every region number and every sub-region slot can be reached directly. It sweeps all eight permission codes against both privilege levels and both directions. It also sweeps size codes from 0 to 12, probing each region edge from both sides. Sub-region masks are probed on all eight slots of a 256-byte region, and on a 128-byte region where the masks must have no effect. Expected faults come from an arithmetic range model of the programmed regions, kept in the bench.

// File: rtl/memprot_pkg.sv
package memprot_pkg;

  typedef enum logic [1:0] {
    CFG_CTRL = 2'd0,
    CFG_SEL  = 2'd1,
    CFG_BASE = 2'd2,
    CFG_ATTR = 2'd3
  } cfg_idx_e;

  typedef struct packed {
    logic [2:0] ap;
    logic [5:0] mtype;
    logic [7:0] srd;
    logic [4:0] size;
    logic       en;
  } rgn_attr_t;

  // Permission decode: returns 1 when the access is allowed
  function automatic logic ap_allows(input logic [2:0] ap, input logic wr, input logic priv);
    logic ok;
    unique case (ap)
      3'b001:  ok = priv;
      3'b010:  ok = priv | ~wr;
      3'b011:  ok = 1'b1;
      3'b101:  ok = priv & ~wr;
      3'b110,
      3'b111:  ok = ~wr;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/memprot_regs.sv
module memprot_regs
  import memprot_pkg::*;
#(
  parameter int unsigned N_REG  = 8,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned REG_W = $clog2(N_REG),
  localparam int unsigned BASE_W = ADDR_W - 5
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cfg_we_i,
  input  logic [1:0]                      cfg_idx_i,
  input  logic [ADDR_W-1:0]               cfg_wdata_i,
  output logic [ADDR_W-1:0]               cfg_rdata_o,
  output logic [2:0]                      ctrl_o,
  output logic [REG_W-1:0]                sel_o,
  output logic [N_REG-1:0][BASE_W-1:0]    base_o,
  output rgn_attr_t [N_REG-1:0]           attr_o
);

  logic [2:0]                   ctrl_q;
  logic [REG_W-1:0]             sel_q;
  logic [N_REG-1:0][BASE_W-1:0] base_q;
  rgn_attr_t [N_REG-1:0]        attr_q;

  logic             base_pick;
  logic [REG_W-1:0] wr_rgn;

  assign base_pick = cfg_we_i && (cfg_idx_e'(cfg_idx_i) == CFG_BASE) && cfg_wdata_i[4];
  assign wr_rgn    = base_pick ? cfg_wdata_i[REG_W-1:0] : sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sel_q  <= '0;
    end else if (cfg_we_i) begin
      if (cfg_idx_e'(cfg_idx_i) == CFG_CTRL) ctrl_q <= cfg_wdata_i[2:0];
      if (cfg_idx_e'(cfg_idx_i) == CFG_SEL)  sel_q  <= cfg_wdata_i[REG_W-1:0];
      if (base_pick)                          sel_q  <= cfg_wdata_i[REG_W-1:0];
    end
  end

  for (genvar r = 0; r < N_REG; r++) begin : g_rgn
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[r] <= '0;
        attr_q[r] <= '0;
      end else if (cfg_we_i && wr_rgn == REG_W'(r)) begin
        if (cfg_idx_e'(cfg_idx_i) == CFG_BASE) base_q[r] <= cfg_wdata_i[ADDR_W-1:5];
        if (cfg_idx_e'(cfg_idx_i) == CFG_ATTR) begin
          attr_q[r].ap    <= cfg_wdata_i[26:24];
          attr_q[r].mtype <= cfg_wdata_i[21:16];
          attr_q[r].srd   <= cfg_wdata_i[15:8];
          attr_q[r].size  <= cfg_wdata_i[5:1];
          attr_q[r].en    <= cfg_wdata_i[0];
        end
      end
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    unique case (cfg_idx_e'(cfg_idx_i))
      CFG_CTRL: cfg_rdata_o[2:0] = ctrl_q;
      CFG_SEL:  cfg_rdata_o[REG_W-1:0] = sel_q;
      CFG_BASE: begin
        cfg_rdata_o[ADDR_W-1:5]  = base_q[sel_q];
        cfg_rdata_o[REG_W-1:0]   = sel_q;
      end
      CFG_ATTR: begin
        cfg_rdata_o[26:24] = attr_q[sel_q].ap;
        cfg_rdata_o[21:16] = attr_q[sel_q].mtype;
        cfg_rdata_o[15:8]  = attr_q[sel_q].srd;
        cfg_rdata_o[5:1]   = attr_q[sel_q].size;
        cfg_rdata_o[0]     = attr_q[sel_q].en;
      end
      default: cfg_rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign sel_o  = sel_q;
  assign base_o = base_q;
  assign attr_o = attr_q;

endmodule

// File: rtl/memprot_match.sv
module memprot_match #(
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned BASE_W = ADDR_W - 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [4:0]        size_i,
  input  logic [7:0]        srd_i,
  input  logic              en_i,
  output logic              hit_o
);

  logic [5:0]        sz_eff;
  logic [5:0]        nbits;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] full_base;
  logic [ADDR_W-1:0] slot_sh;
  logic              in_rng;
  logic              slot_off;

  // sizes below 32 bytes are clamped to 32 bytes
  assign sz_eff    = (size_i < 5'd4) ? 6'd4 : {1'b0, size_i};
  assign nbits     = sz_eff + 6'd1;
  assign full_base = {base_i, 5'b0};

  always_comb begin
    for (int i = 0; i < ADDR_W; i++) mask[i] = (i >= int'(nbits));
  end

  assign in_rng   = ((addr_i ^ full_base) & mask) == '0;
  assign slot_sh  = addr_i >> (nbits - 6'd3);
  assign slot_off = (sz_eff >= 6'd7) && srd_i[slot_sh[2:0]];
  assign hit_o    = en_i && in_rng && !slot_off;

endmodule

// File: rtl/memprot_perm.sv
module memprot_perm
  import memprot_pkg::*;
#(
  parameter int unsigned N_REG = 8
) (
  input  logic [N_REG-1:0]      hit_i,
  input  logic [N_REG-1:0][2:0] ap_i,
  input  logic                  write_i,
  input  logic                  priv_i,
  input  logic                  prot_en_i,
  input  logic                  dflt_en_i,
  input  logic                  sys_i,
  output logic                  deny_o,
  output logic                  any_hit_o
);

  logic [2:0] ap_sel;

  // ascending scan: the highest-numbered hit wins
  always_comb begin
    ap_sel = '0;
    for (int r = 0; r < N_REG; r++) begin
      if (hit_i[r]) ap_sel = ap_i[r];
    end
  end

  assign any_hit_o = |hit_i;

  always_comb begin
    if (!prot_en_i || sys_i)  deny_o = 1'b0;
    else if (!any_hit_o)      deny_o = !(priv_i && dflt_en_i);
    else                      deny_o = !ap_allows(ap_sel, write_i, priv_i);
  end

endmodule

// File: rtl/memprot_unit.sv
module memprot_unit
  import memprot_pkg::*;
#(
  parameter int unsigned     N_REG  = 8,
  parameter int unsigned     ADDR_W = 32,
  parameter logic [31:0]     SYS_LO = 32'hE000_0000,
  localparam int unsigned    REG_W  = $clog2(N_REG),
  localparam int unsigned    BASE_W = ADDR_W - 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_idx_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  output logic [ADDR_W-1:0] cfg_rdata_o,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  input  logic              acc_priv_i,
  output logic              fault_o
);

  logic [2:0]                   ctrl;
  logic [REG_W-1:0]             rnr_q;
  logic [N_REG-1:0][BASE_W-1:0] base;
  rgn_attr_t [N_REG-1:0]        attr;
  logic [N_REG-1:0]             hit;
  logic [N_REG-1:0][2:0]        ap;
  logic                         prot_en;
  logic                         dflt_en;
  logic                         sys_acc;
  logic                         any_hit;
  logic                         deny;
  logic                         fault_q;

  memprot_regs #(.N_REG(N_REG), .ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_idx_i   (cfg_idx_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .ctrl_o      (ctrl),
    .sel_o       (rnr_q),
    .base_o      (base),
    .attr_o      (attr)
  );

  for (genvar r = 0; r < N_REG; r++) begin : g_match
    memprot_match #(.ADDR_W(ADDR_W)) u_match (
      .addr_i (acc_addr_i),
      .base_i (base[r]),
      .size_i (attr[r].size),
      .srd_i  (attr[r].srd),
      .en_i   (attr[r].en),
      .hit_o  (hit[r])
    );
    assign ap[r] = attr[r].ap;
  end

  assign prot_en = ctrl[0];
  assign dflt_en = ctrl[2];
  assign sys_acc = acc_addr_i >= ADDR_W'(SYS_LO);

  memprot_perm #(.N_REG(N_REG)) u_perm (
    .hit_i     (hit),
    .ap_i      (ap),
    .write_i   (acc_write_i),
    .priv_i    (acc_priv_i),
    .prot_en_i (prot_en),
    .dflt_en_i (dflt_en),
    .sys_i     (sys_acc),
    .deny_o    (deny),
    .any_hit_o (any_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= 1'b0;
    else         fault_q <= acc_valid_i && deny;
  end

  assign fault_o = fault_q;

endmodule

// File: rtl/memprot_unit_chk.sv
module memprot_unit_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned REG_W  = 3,
  parameter logic [31:0] SYS_LO = 32'hE000_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [1:0]        cfg_idx_i,
  input logic [ADDR_W-1:0] cfg_wdata_i,
  input logic              acc_valid_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              acc_priv_i,
  input logic              fault_o,
  input logic              prot_en,
  input logic              dflt_en,
  input logic              any_hit,
  input logic [REG_W-1:0]  rnr_q
);

  AST_FAULT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(acc_valid_i)); // R11

  AST_OFF_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prot_en |=> !fault_o); // R9

  AST_SYS_EXEMPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_addr_i >= ADDR_W'(SYS_LO)) |=> !fault_o); // R10

  AST_USER_NOHIT_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_priv_i && prot_en && !any_hit && acc_addr_i < ADDR_W'(SYS_LO)) |=> fault_o); // R8

  AST_PRIV_DEFAULT_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_priv_i && dflt_en && !any_hit) |=> !fault_o); // R8

  AST_BASE_PICKS_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_idx_i == 2'd2 && cfg_wdata_i[4]) |=> rnr_q == $past(cfg_wdata_i[REG_W-1:0])); // R2

endmodule

bind memprot_unit memprot_unit_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W), .SYS_LO(SYS_LO)) u_chk (.*);

// File: tb/memprot_unit_bench.sv
module memprot_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        acc_priv = 1'b0;
  logic        fault;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] sh_base [8];
  logic [31:0] sh_attr [8];
  logic [31:0] sh_ctrl;
  int          sh_sel;

  always #10 clk = ~clk;

  memprot_unit u_memprot_unit (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (cfg_we),
    .cfg_idx_i   (cfg_idx),
    .cfg_wdata_i (cfg_wdata),
    .cfg_rdata_o (cfg_rdata),
    .acc_valid_i (acc_valid),
    .acc_addr_i  (acc_addr),
    .acc_write_i (acc_write),
    .acc_priv_i  (acc_priv),
    .fault_o     (fault)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cfg_wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx == 0) sh_ctrl = d & 32'h7;
    if (idx == 1) sh_sel = int'(d[2:0]);
    if (idx == 2) begin
      if (d[4]) sh_sel = int'(d[2:0]);
      sh_base[sh_sel] = d & 32'hFFFF_FFE0;
    end
    if (idx == 3) sh_attr[sh_sel] = d & 32'h073F_FF3F;
  endtask

  task automatic cfg_rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    cfg_idx = 2'(idx);
    #1 d = cfg_rdata;
  endtask

  task automatic prog(input int r, input logic [31:0] b, input logic [31:0] a);
    cfg_wr(1, 32'(r));
    cfg_wr(2, b);
    cfg_wr(3, a);
  endtask

  task automatic access(input logic [31:0] a, input bit wr, input bit pr, input bit vld, output logic f);
    @(negedge clk);
    acc_valid = vld; acc_addr = a; acc_write = wr; acc_priv = pr;
    @(negedge clk);
    f = fault;
    acc_valid = 1'b0; acc_addr = '0;
  endtask

  function automatic bit ap_ok(input int ap, input bit wr, input bit pr);
    case (ap)
      1: return pr;
      2: return pr || !wr;
      3: return 1'b1;
      5: return pr && !wr;
      6, 7: return !wr;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit model(input logic [31:0] a, input bit wr, input bit pr);
    int hit = -1;
    if (!sh_ctrl[0]) return 1'b0;
    if (a >= 32'hE000_0000) return 1'b0;
    for (int r = 0; r < 8; r++) begin
      longint unsigned len, lo;
      int s;
      if (!sh_attr[r][0]) continue;
      s = int'(sh_attr[r][5:1]);
      if (s < 4) s = 4;
      len = 64'd1 << (s + 1);
      lo  = (longint'(sh_base[r]) / len) * len;
      if (longint'(a) >= lo && longint'(a) < lo + len) begin
        int k = int'((longint'(a) - lo) / (len / 8));
        if (s >= 7 && sh_attr[r][8 + k]) continue;
        hit = r;
      end
    end
    if (hit < 0) return !(pr && sh_ctrl[2]);
    return !ap_ok(int'(sh_attr[hit][26:24]), wr, pr);
  endfunction

  task automatic probe(input string req, input logic [31:0] a, input bit wr, input bit pr);
    logic f;
    access(a, wr, pr, 1'b1, f);
    check(req, 32'(f), 32'(model(a, wr, pr)));
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic f;
    for (int r = 0; r < 8; r++) begin sh_base[r] = '0; sh_attr[r] = '0; end
    sh_ctrl = '0; sh_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      cfg_rd(i, d);
      check("R1 reset", d, 32'h0);
    end
    check("R11 reset fault", 32'(fault), 32'h0);

    // R1 control and selector readback
    cfg_wr(0, 32'hFFFF_FFFF); cfg_rd(0, d); check("R1 ctrl mask", d, 32'h7);
    cfg_wr(0, 32'h5);         cfg_rd(0, d); check("R1 ctrl", d, 32'h5);
    cfg_wr(1, 32'h6);         cfg_rd(1, d); check("R1 sel", d, 32'h6);

    // R3 attribute layout
    cfg_wr(3, 32'h0102_EE0F); cfg_rd(3, d); check("R3 attr", d, 32'h0102_EE0F);
    cfg_wr(3, 32'hFFFF_FFFF); cfg_rd(3, d); check("R3 attr mask", d, 32'h073F_FF3F);

    // R2 base with region pick, then without
    cfg_wr(2, 32'h0000_7013); cfg_rd(1, d); check("R2 pick sel", d, 32'h3);
    cfg_rd(2, d); check("R2 base rd", d, 32'h0000_7003);
    cfg_wr(2, 32'h0000_8005); cfg_rd(2, d); check("R2 no pick", d, 32'h0000_8003);
    cfg_rd(1, d); check("R2 sel kept", d, 32'h3);
    cfg_wr(1, 32'h6); cfg_rd(3, d); check("R2 other rgn intact", d, 32'h073F_FF3F);

    for (int r = 0; r < 8; r++) prog(r, 32'h0, 32'h0);
    cfg_wr(0, 32'h1);

    // R6 permission sweep
    for (int ap = 0; ap < 8; ap++) begin
      prog(0, 32'h1000, (32'(ap) << 24) | (32'd4 << 1) | 32'd1);
      for (int pw = 0; pw < 4; pw++) probe("R6 ap", 32'h1004, pw[0], pw[1]);
    end

    // R4 size sweep with unprivileged reads
    for (int s = 0; s < 13; s++) begin
      int n = (s < 4) ? 5 : s + 1;
      prog(0, 32'h0, 32'h0300_0000 | (32'(s) << 1) | 32'd1);
      probe("R4 inside", (32'd1 << n) - 32'd4, 1'b0, 1'b0);
      probe("R4 edge", 32'd1 << n, 1'b0, 1'b0);
    end
    prog(0, 32'h1010, 32'h0300_0000 | (32'd4 << 1) | 32'd1);
    probe("R4 base align", 32'h1000, 1'b1, 1'b0);
    probe("R4 base align hi", 32'h1020, 1'b1, 1'b0);

    // R5 sub-region disables
    begin
      logic [7:0] masks [3] = '{8'hEE, 8'h55, 8'h00};
      for (int m = 0; m < 3; m++) begin
        prog(0, 32'h7000, 32'h0300_0000 | (32'(masks[m]) << 8) | (32'd7 << 1) | 32'd1);
        for (int k = 0; k < 8; k++) probe("R5 slot", 32'h7004 + 32'(k * 32), 1'b1, 1'b0);
      end
    end
    prog(0, 32'h7000, 32'h0300_FF00 | (32'd6 << 1) | 32'd1);
    probe("R5 small ignored", 32'h7000, 1'b1, 1'b0);
    probe("R5 small ignored hi", 32'h7040, 1'b1, 1'b0);
    prog(0, 32'h0, 32'h0);

    // R7 overlap priority
    prog(1, 32'h2000, 32'h0300_0000 | (32'd7 << 1) | 32'd1);
    prog(5, 32'h2000, 32'h0600_0000 | (32'd4 << 1) | 32'd1);
    probe("R7 high wins", 32'h2000, 1'b1, 1'b0);
    probe("R7 low only", 32'h2040, 1'b1, 1'b0);
    prog(5, 32'h2000, 32'h0300_0000 | (32'd4 << 1) | 32'd1);
    prog(1, 32'h2000, 32'h0600_0000 | (32'd7 << 1) | 32'd1);
    probe("R7 high permits", 32'h2004, 1'b1, 1'b0);
    probe("R7 low denies", 32'h2044, 1'b1, 1'b0);

    // R8 no-match handling
    probe("R8 priv no dflt", 32'h9000_0000, 1'b0, 1'b1);
    cfg_wr(0, 32'h5);
    probe("R8 priv dflt", 32'h9000_0000, 1'b1, 1'b1);
    probe("R8 user", 32'h9000_0000, 1'b0, 1'b0);

    // R10 system space
    probe("R10 sys", 32'hE000_ED94, 1'b1, 1'b0);
    probe("R10 sys top", 32'hFFFF_FFFC, 1'b1, 1'b0);

    // R11 valid gating and one-cycle registration
    access(32'h9000_0000, 1'b1, 1'b0, 1'b0, f);
    check("R11 no valid", 32'(f), 32'h0);
    access(32'h9000_0000, 1'b1, 1'b0, 1'b1, f);
    check("R11 fault", 32'(f), 32'h1);
    @(negedge clk);
    check("R11 clears", 32'(fault), 32'h0);

    // R9 global disable
    cfg_wr(0, 32'h4);
    access(32'h2044, 1'b1, 1'b0, 1'b1, f);
    check("R9 off", 32'(f), 32'h0);
    access(32'h9000_0000, 1'b1, 1'b0, 1'b1, f);
    check("R9 off nohit", 32'(f), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule